// File: doc/BRIEF.md
# Statistical Entropy Health Tester

This block watches a serial stream of bits from a noise source and grades it in back-to-back windows of a fixed length. Within each window it runs three statistical tests side by side. The first tallies the ones. The second splits the stream into 4-bit groups and keeps a histogram of the sixteen possible values, then forms the sum of the squared histogram counts. The third records runs of identical bits by polarity and by length. When the final bit of a window arrives, the block spends a short evaluation phase squaring and summing the histogram. It then reports a verdict for each test and starts over with cleared state.

Bits enter one at a time with a valid strobe, and the producer may leave idle cycles between them. All limits are elaboration-time parameters. A consumer such as an alarm or shutdown controller watches the window-done strobe and the three fail pulses that go with it.

Top module: `eht_top`

## Requirements
- R1: A window is exactly WIN_BITS accepted bits. `win_done` is high for one cycle, registered on the 17th rising edge after the edge that accepts the window's final bit.
- R2: `mono_fail` is set with `win_done` unless MONO_LO < (number of ones) < MONO_HI, with both limits excluded.
- R3: Every four consecutive accepted bits form one value, and the earliest of the four is the most significant bit. Sixteen counters record how often each value occurs. `poker_fail` is set if any counter lies outside [PK_CNT_LO, PK_CNT_HI], with both limits included.
- R4: `poker_fail` is also set if the sum of the sixteen squared counters lies outside [PK_SQ_LO, PK_SQ_HI], with both limits included.
- R5: A run is a maximal stretch of identical bits. Runs of zeros and runs of ones are counted separately, in buckets for length 1, 2, 3, 4, 5 and 6-or-more. `runs_fail` is set if any of the twelve counts for bucket k lies outside [RUN_LO[k], RUN_HI[k]], with both limits included. Both polarities use the same limits.
- R6: A run that is still open when the window's final bit arrives is counted in that window. No run continues into the next window.
- R7: `mono_fail`, `poker_fail` and `runs_fail` are high only in the cycle in which `win_done` is high.
- R8: Cycles with `bit_vld` low do not change any result. Bits presented with `bit_vld` high during the 17 cycles after a window's final bit is accepted are discarded.
- R9: After `win_done`, all counters start from zero. Each verdict depends only on the bits of its own window.
- R10: Synchronous active-high `rst` holds all outputs low and discards any partial window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Sample from the noise source |
| mono_fail | output | 1 | Ones-count verdict, pulses with `win_done` |
| poker_fail | output | 1 | 4-bit histogram verdict, pulses with `win_done` |
| runs_fail | output | 1 | Run-length verdict, pulses with `win_done` |
| win_done | output | 1 | One-cycle strobe marking the end of a window's evaluation |

## Verification
The bench builds the block with 64-bit windows. That gives sixteen 4-bit groups per window, so a random window lands near every limit. The limits are set tight: ones must fall strictly between 24 and 40, each histogram counter at most 3, the square sum within 16 to 40, and run limits sized for about sixteen runs of each polarity. These values make every verdict both pass and fail under random data. They also make the exact limit values easy to reach in directed windows: 16 distinct values give a square sum of exactly 16, and chosen patterns give 40 and 42. A directed window has its single passing length-1 run of ones as the open run at the window's end.

// File: rtl/eht_pkg.sv
package eht_pkg;

    localparam int unsigned NIB_BITS = 4;
    localparam int unsigned NCELL    = 1 << NIB_BITS;
    localparam int unsigned CELL_IW  = NIB_BITS;
    localparam int unsigned NRUN     = 6;
    localparam int unsigned RLEN_W   = 3;

    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_SWEEP   = 2'd1,
        PH_JUDGE   = 2'd2
    } phase_e;

    typedef struct packed {
        logic mono;
        logic poker;
        logic runs;
    } verdict_t;

    // true when v is not strictly between lo and hi
    function automatic logic outside_open(input int unsigned v, input int unsigned lo,
                                          input int unsigned hi);
        return !((v > lo) && (v < hi));
    endfunction

    // true when v is not within [lo, hi]
    function automatic logic outside_closed(input int unsigned v, input int unsigned lo,
                                            input int unsigned hi);
        return (v < lo) || (v > hi);
    endfunction

    // lengthen a run, saturating at the open-ended bucket
    function automatic logic [RLEN_W-1:0] run_step(input logic [RLEN_W-1:0] len);
        return (len >= RLEN_W'(NRUN)) ? RLEN_W'(NRUN) : len + 1'b1;
    endfunction

endpackage

// File: rtl/eht_monobit.sv
module eht_monobit import eht_pkg::*; #(
    parameter int unsigned WIN_BITS = 20000,
    parameter int unsigned LO       = 9654,
    parameter int unsigned HI       = 10346
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic bit_in,
    input  logic clear,
    output logic fail
);
    localparam int unsigned CW = $clog2(WIN_BITS + 1);

    logic [CW-1:0] ones;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ones <= '0;
        end else if (take && bit_in) begin
            ones <= ones + 1'b1;
        end
    end

    assign fail = outside_open(32'(ones), LO, HI);

    // R2: the tally can never exceed the window length
    p_ones_cap_r2: assert property (@(posedge clk) disable iff (rst)
        32'(ones) <= WIN_BITS);

endmodule

// File: rtl/eht_poker.sv
module eht_poker import eht_pkg::*; #(
    parameter int unsigned WIN_BITS = 20000,
    parameter int unsigned CNT_LO   = 250,
    parameter int unsigned CNT_HI   = 375,
    parameter int unsigned SQ_LO    = 1562822,
    parameter int unsigned SQ_HI    = 1580437
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic               bit_in,
    input  logic               clear,
    input  logic               sweep,
    input  logic [CELL_IW-1:0] sweep_idx,
    output logic               fail
);
    localparam int unsigned NNIB = WIN_BITS / NIB_BITS;
    localparam int unsigned PW   = $clog2(NNIB + 1);
    localparam int unsigned SW   = 2 * PW + CELL_IW;
    localparam int unsigned POSW = $clog2(NIB_BITS);

    logic [NIB_BITS-2:0] head;
    logic [POSW-1:0]     pos;
    logic [PW-1:0]       cnt [NCELL];
    logic [SW-1:0]       acc;
    logic [NCELL-1:0]    cell_bad;
    logic                nib_done;
    logic [CELL_IW-1:0]  nib_val;

    assign nib_done = take && (pos == POSW'(NIB_BITS - 1));
    assign nib_val  = {head, bit_in};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head <= '0;
            pos  <= '0;
            acc  <= '0;
            for (int i = 0; i < NCELL; i++) cnt[i] <= '0;
        end else begin
            if (take) begin
                head <= {head[NIB_BITS-3:0], bit_in};
                pos  <= nib_done ? '0 : pos + 1'b1;
            end
            if (nib_done) cnt[nib_val] <= cnt[nib_val] + 1'b1;
            if (sweep) acc <= acc + SW'(cnt[sweep_idx]) * SW'(cnt[sweep_idx]);
        end
    end

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        assign cell_bad[g] = outside_closed(32'(cnt[g]), CNT_LO, CNT_HI);

        // R3: no value can be seen more often than there are groups
        p_cell_cap_r3: assert property (@(posedge clk) disable iff (rst)
            32'(cnt[g]) <= NNIB);
    end

    assign fail = (|cell_bad) || outside_closed(32'(acc), SQ_LO, SQ_HI);

    // R4: the square sum never exceeds the all-in-one-cell case
    p_acc_cap_r4: assert property (@(posedge clk) disable iff (rst)
        64'(acc) <= 64'(NNIB) * 64'(NNIB));

endmodule

// File: rtl/eht_runs.sv
module eht_runs import eht_pkg::*; #(
    parameter int unsigned WIN_BITS     = 20000,
    parameter int unsigned RUN_LO [NRUN] = '{2267, 1079, 502, 223, 90, 90},
    parameter int unsigned RUN_HI [NRUN] = '{2733, 1421, 748, 402, 223, 223}
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic last,
    input  logic bit_in,
    input  logic clear,
    output logic fail
);
    localparam int unsigned CW = $clog2(WIN_BITS + 1);

    logic              cur;
    logic [RLEN_W-1:0] len;
    logic [RLEN_W-1:0] new_len;
    logic              brk;
    logic              close_old;
    logic [CW-1:0]     cnt     [2][NRUN];
    logic              hit_old [2][NRUN];
    logic              hit_new [2][NRUN];
    logic [2*NRUN-1:0] bad;

    assign brk       = (len == '0) || (bit_in != cur);
    assign close_old = take && (len != '0) && (bit_in != cur);
    assign new_len   = brk ? RLEN_W'(1) : run_step(len);

    always_comb begin
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < NRUN; k++) begin
                hit_old[p][k] = close_old && (cur == 1'(p)) && (len == RLEN_W'(k + 1));
                hit_new[p][k] = last && (bit_in == 1'(p)) && (new_len == RLEN_W'(k + 1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur <= 1'b0;
            len <= '0;
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < NRUN; k++) cnt[p][k] <= '0;
        end else begin
            if (take) begin
                cur <= bit_in;
                len <= last ? '0 : new_len;
            end
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < NRUN; k++)
                    cnt[p][k] <= cnt[p][k] + CW'(hit_old[p][k]) + CW'(hit_new[p][k]);
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_pol
        for (genvar k = 0; k < NRUN; k++) begin : g_len
            assign bad[p*NRUN+k] = outside_closed(32'(cnt[p][k]), RUN_LO[k], RUN_HI[k]);
        end
    end

    assign fail = |bad;

    // R5: run length stays within the saturating bucket range
    p_runlen_cap_r5: assert property (@(posedge clk) disable iff (rst)
        32'(len) <= NRUN);

    // R6: the run that ends a window is credited, so nothing stays open
    p_no_open_run_r6: assert property (@(posedge clk) disable iff (rst)
        last |=> (len == '0));

endmodule

// File: rtl/eht_top.sv
module eht_top import eht_pkg::*; #(
    parameter int unsigned WIN_BITS      = 20000,
    parameter int unsigned MONO_LO       = 9654,
    parameter int unsigned MONO_HI       = 10346,
    parameter int unsigned PK_CNT_LO     = 250,
    parameter int unsigned PK_CNT_HI     = 375,
    parameter int unsigned PK_SQ_LO      = 1562822,
    parameter int unsigned PK_SQ_HI      = 1580437,
    parameter int unsigned RUN_LO [NRUN] = '{2267, 1079, 502, 223, 90, 90},
    parameter int unsigned RUN_HI [NRUN] = '{2733, 1421, 748, 402, 223, 223}
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic mono_fail,
    output logic poker_fail,
    output logic runs_fail,
    output logic win_done
);
    localparam int unsigned BW = $clog2(WIN_BITS);

    phase_e             phase;
    logic [BW-1:0]      bit_cnt;
    logic [CELL_IW-1:0] sw_idx;
    logic               take;
    logic               last;
    logic               sweep;
    logic               clear;
    verdict_t           raw;
    verdict_t           outv;

    assign take  = bit_vld && (phase == PH_COLLECT);
    assign last  = take && (bit_cnt == BW'(WIN_BITS - 1));
    assign sweep = (phase == PH_SWEEP);
    assign clear = (phase == PH_JUDGE);

    eht_monobit #(.WIN_BITS(WIN_BITS), .LO(MONO_LO), .HI(MONO_HI)) u_mono (
        .clk(clk), .rst(rst), .take(take), .bit_in(bit_in), .clear(clear),
        .fail(raw.mono)
    );

    eht_poker #(
        .WIN_BITS(WIN_BITS), .CNT_LO(PK_CNT_LO), .CNT_HI(PK_CNT_HI),
        .SQ_LO(PK_SQ_LO), .SQ_HI(PK_SQ_HI)
    ) u_poker (
        .clk(clk), .rst(rst), .take(take), .bit_in(bit_in), .clear(clear),
        .sweep(sweep), .sweep_idx(sw_idx), .fail(raw.poker)
    );

    eht_runs #(.WIN_BITS(WIN_BITS), .RUN_LO(RUN_LO), .RUN_HI(RUN_HI)) u_runs (
        .clk(clk), .rst(rst), .take(take), .last(last), .bit_in(bit_in),
        .clear(clear), .fail(raw.runs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_COLLECT;
            bit_cnt  <= '0;
            sw_idx   <= '0;
            win_done <= 1'b0;
            outv     <= '0;
        end else begin
            win_done <= 1'b0;
            outv     <= '0;
            case (phase)
                PH_COLLECT: begin
                    if (last) begin
                        bit_cnt <= '0;
                        sw_idx  <= '0;
                        phase   <= PH_SWEEP;
                    end else if (take) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_SWEEP: begin
                    sw_idx <= sw_idx + 1'b1;
                    if (sw_idx == CELL_IW'(NCELL - 1)) phase <= PH_JUDGE;
                end
                PH_JUDGE: begin
                    win_done <= 1'b1;
                    outv     <= raw;
                    phase    <= PH_COLLECT;
                end
                default: phase <= PH_COLLECT;
            endcase
        end
    end

    assign mono_fail  = outv.mono;
    assign poker_fail = outv.poker;
    assign runs_fail  = outv.runs;

    // R7: a verdict never appears without the window strobe
    p_fail_needs_done_r7: assert property (@(posedge clk) disable iff (rst)
        (mono_fail || poker_fail || runs_fail) |-> win_done);

    // R1: the window strobe lasts one cycle
    p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
        win_done |=> !win_done);

    // R8: no bit is counted while the window is being evaluated
    p_eval_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_COLLECT) |-> (bit_cnt == '0));

    // R9: a fresh window begins when the strobe is seen
    p_done_fresh_r9: assert property (@(posedge clk) disable iff (rst)
        win_done |-> (bit_cnt == '0) && (phase == PH_COLLECT));

endmodule

// File: tb/eht_top_tb_top.sv
`timescale 1ns/1ps
module eht_top_tb_top;
    import eht_pkg::*;

    localparam int unsigned W   = 64;
    localparam int unsigned MLO = 24;
    localparam int unsigned MHI = 40;
    localparam int unsigned CLO = 0;
    localparam int unsigned CHI = 3;
    localparam int unsigned SLO = 16;
    localparam int unsigned SHI = 40;
    localparam int unsigned RLO [NRUN] = '{3, 1, 0, 0, 0, 0};
    localparam int unsigned RHI [NRUN] = '{13, 8, 5, 4, 3, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic mono_fail, poker_fail, runs_fail, win_done;

    int n_chk = 0;
    int n_bad = 0;
    bit fall_pend = 1'b0;

    always #4 clk = ~clk;

    eht_top #(
        .WIN_BITS(W), .MONO_LO(MLO), .MONO_HI(MHI), .PK_CNT_LO(CLO), .PK_CNT_HI(CHI),
        .PK_SQ_LO(SLO), .PK_SQ_HI(SHI), .RUN_LO(RLO), .RUN_HI(RHI)
    ) dut_i (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .mono_fail(mono_fail), .poker_fail(poker_fail), .runs_fail(runs_fail),
        .win_done(win_done)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int exp_mono(input logic [W-1:0] w);
        int ones = $countones(w);
        return (ones > MLO && ones < MHI) ? 0 : 1;
    endfunction

    function automatic int exp_poker(input logic [W-1:0] w);
        int cnt [NCELL];
        int sq = 0;
        int bad = 0;
        for (int i = 0; i < NCELL; i++) cnt[i] = 0;
        for (int j = 0; j < W / 4; j++)
            cnt[{w[4*j], w[4*j+1], w[4*j+2], w[4*j+3]}]++;
        for (int i = 0; i < NCELL; i++) begin
            sq += cnt[i] * cnt[i];
            if (cnt[i] < int'(CLO) || cnt[i] > int'(CHI)) bad = 1;
        end
        if (sq < int'(SLO) || sq > int'(SHI)) bad = 1;
        return bad;
    endfunction

    function automatic int exp_runs(input logic [W-1:0] w);
        int cnt [2][NRUN];
        int len = 0;
        int cur = 0;
        int bad = 0;
        for (int p = 0; p < 2; p++) for (int k = 0; k < NRUN; k++) cnt[p][k] = 0;
        for (int i = 0; i < W; i++) begin
            if (len == 0 || int'(w[i]) != cur) begin
                if (len != 0) cnt[cur][(len > 6 ? 6 : len) - 1]++;
                cur = int'(w[i]);
                len = 1;
            end else begin
                len++;
            end
        end
        cnt[cur][(len > 6 ? 6 : len) - 1]++;
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < NRUN; k++)
                if (cnt[p][k] < int'(RLO[k]) || cnt[p][k] > int'(RHI[k])) bad = 1;
        return bad;
    endfunction

    // place 16 packed values so the earliest bit of each group is its MSB
    function automatic logic [W-1:0] from_nibs(input logic [W-1:0] p);
        logic [W-1:0] w;
        for (int j = 0; j < W / 4; j++)
            for (int k = 0; k < 4; k++) w[4*j+k] = p[4*j+3-k];
        return w;
    endfunction

    task automatic drive_bit(input logic b, input logic v);
        @(negedge clk);
        if (fall_pend) begin
            chk("R1 win_done one cycle", int'(win_done), 0);
            fall_pend = 1'b0;
        end
        bit_vld = v;
        bit_in  = b;
    endtask

    task automatic run_window(input logic [W-1:0] w, input int gap_pct, input string tag);
        for (int i = 0; i < W; i++) begin
            while (int'($urandom_range(99)) < gap_pct) drive_bit(1'($urandom_range(1)), 1'b0);
            drive_bit(w[i], 1'b1);
        end
        // R8: valid junk during evaluation must be dropped
        for (int j = 0; j < 16; j++) drive_bit(1'($urandom_range(1)), 1'b1);
        @(negedge clk);
        chk({"R1 no early done ", tag}, int'(win_done), 0);
        chk({"R7 no early verdict ", tag}, int'(mono_fail | poker_fail | runs_fail), 0);
        bit_vld = 1'b1;
        bit_in  = 1'($urandom_range(1));
        @(negedge clk);
        chk({"R1 done latency ", tag}, int'(win_done), 1);
        chk({"R2/R8 monobit ", tag}, int'(mono_fail), exp_mono(w));
        chk({"R3/R4/R9 poker ", tag}, int'(poker_fail), exp_poker(w));
        chk({"R5/R6 runs ", tag}, int'(runs_fail), exp_runs(w));
        bit_vld   = 1'b0;
        fall_pend = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] w;
        int lens [12] = '{1, 1, 1, 2, 1, 1, 2, 2, 6, 3, 43, 1};
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        // R10: outputs quiet in reset
        chk("R10 reset outputs", int'({mono_fail, poker_fail, runs_fail, win_done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 outputs after reset", int'({mono_fail, poker_fail, runs_fail, win_done}), 0);

        // R10: a partial window is thrown away by reset
        for (int i = 0; i < 30; i++) drive_bit(1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        bit_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_window(from_nibs(64'hFEDCBA9876543210), 0, "R10 after partial");

        // directed corner cases
        run_window('0, 0, "all zeros");
        run_window({W{1'b1}}, 10, "all ones");
        run_window({(W/2){2'b10}}, 0, "alternating");
        run_window((64'd1 << 24) - 64'd1, 0, "ones=24");
        run_window((64'd1 << 25) - 64'd1, 0, "ones=25");
        run_window((64'd1 << 39) - 64'd1, 0, "ones=39");
        run_window((64'd1 << 40) - 64'd1, 0, "ones=40");
        run_window(from_nibs(64'hFEDCBA9876543210), 20, "R4 square sum 16");
        run_window(from_nibs(64'h7654333222111000), 0, "R4 square sum 40");
        run_window(from_nibs(64'h6544333222111000), 0, "R4 square sum 42");
        run_window(from_nibs(64'h0000000000000000), 0, "R3 one cell 16");

        // R6: the lone closing run of ones is the third length-1 one-run
        begin
            int pos = 0;
            for (int r = 0; r < 12; r++)
                for (int k = 0; k < lens[r]; k++) begin
                    w[pos] = 1'(r % 2);
                    pos++;
                end
        end
        run_window(w, 0, "R6 open final run");
        // R9: same-polarity start right after a window of ones
        run_window({W{1'b1}}, 0, "R9 prev ones");
        run_window({{(W-8){1'b0}}, 8'hFF}, 0, "R9 starts with ones");

        // constrained random windows with idle gaps
        for (int n = 0; n < 24; n++) begin
            w = {$urandom(), $urandom()};
            run_window(w, (n % 3) * 20, "random");
        end

        drive_bit(1'b0, 1'b0);
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule